// File: doc/BRIEF.md
# Register-Controlled SPI Master

This block is an SPI master that a processor drives through a small register bus. Software first programs a clock divider and a control word: the SPI mode (clock idle level and sampling phase), which of three chip-select lines to drive, and the polarity of each line. Software then sets the transfer-active bit and streams bytes into a 16-entry transmit queue. The engine shifts each byte out on MOSI, most significant bit first. At the same time it samples MISO into a 16-entry receive queue, which software drains by reading the data address.

Status bits report the state of the transfer: transfer complete, receive data present, transmit room, receive needs reading, and receive full. Two level-sensitive interrupt lines follow the complete flag and the needs-reading flag, each through its own enable bit. A write-one pulse field in the control word flushes either queue. When the receive queue is full, the engine holds the next byte until software frees a slot.

Top module: `spi_host_engine`

## Requirements
- R1: An SCLK half period lasts D/2 clock cycles. D is the divider value with bit 0 forced to 0, and D of 0 stands for 65536. So 7 gives 3 cycles, 2 gives 1 cycle, and 0 or 1 gives 32768 cycles.
- R2: Control bits [1:0] pick the chip select: 0, 1 or 2 drives line 0, 1 or 2 active. Code 3 drives no line active.
- R3: While transfer-active (control bit 7) is 0, every chip-select line is inactive and status bits 16 and 19 read 0. A byte being shifted is abandoned, and SCLK returns to its idle level.
- R4: Control bits [5:4] are a write-one flush: bit 4 empties the transmit queue and bit 5 empties the receive queue. The field reads back 0. When a flush and a transfer-active set come in one write, the flushed bytes are never shifted.
- R5: SCLK idles at control bit 3. With control bit 2 at 0, MISO is sampled on the first edge of each bit; with it at 1, MISO is sampled on the second. Bytes go out MSB first, and each received byte enters the receive queue in the same order, in all four modes.
- R6: Status bit 16 (done) is 1 when transfer-active is set, the transmit queue is empty and no byte is shifting. A new transmit byte clears it.
- R7: Status bit 19 is 1 when the receive queue holds 12 or more bytes. Status bit 20 is 1 at 16 bytes, and no new byte starts until software reads one.
- R8: irq_done is done AND control bit 8. irq_rx is status bit 19 AND control bit 9.
- R9: Control bits [12:10] give the polarity of chip-select lines 0 to 2: a 0 bit means active low, a 1 bit means active high. Their reset value is 0, so after reset all lines sit high.
- R10: Address 0 is the control/status word, address 1 is the data port, and address 2 is the 16-bit divider. Status bit 17 means receive data present and status bit 18 means transmit room. A data-port write while transfer-active is 0 is discarded.
- R11: Reading address 1 returns the oldest received byte and removes it. After reset the control word and the divider read 0 and status reads only bit 18 set.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 24 | Read data, combinational from address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 3 | Chip-select lines |
| irq_done | output | 1 | Transfer-complete interrupt |
| irq_rx | output | 1 | Receive-needs-reading interrupt |

## Verification
The assertions assume that reg_wr and reg_rd are never raised together. They also assume that software changes the mode bits and the divider only while no byte is shifting, because a mid-byte change would break the edge spacing they rely on. The stimulus follows both rules. Every bus access is a single strobe, and the mode or the divider is rewritten only after the done flag has been seen or the transfer has been stopped. MISO is driven by a behavioural slave that updates only after the edge on which the master samples.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam int CTL_SEL_LSB  = 0;
  localparam int CTL_CPHA     = 2;
  localparam int CTL_CPOL     = 3;
  localparam int CTL_FLUSH_TX = 4;
  localparam int CTL_FLUSH_RX = 5;
  localparam int CTL_XFER     = 7;
  localparam int CTL_IE_DONE  = 8;
  localparam int CTL_IE_RX    = 9;
  localparam int CTL_POL_LSB  = 10;

  localparam int ST_DONE    = 16;
  localparam int ST_RX_HAS  = 17;
  localparam int ST_TX_ROOM = 18;
  localparam int ST_RX_NEED = 19;
  localparam int ST_RX_FULL = 20;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_DATA = 2'd1,
    ADR_DIV  = 2'd2,
    ADR_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [2:0] cs_pol;
    logic       ie_rx;
    logic       ie_done;
    logic       xfer_on;
    logic       cpol;
    logic       cpha;
    logic [1:0] cs_sel;
  } ctrl_t;

  // Half period in core cycles: even-rounded divisor / 2, with zero meaning 65536.
  function automatic logic [15:0] half_cycles(input logic [15:0] cdiv);
    if (cdiv[15:1] == 15'd0) return 16'h8000;
    return {1'b0, cdiv[15:1]};
  endfunction

  // Pin level for a chip-select line given its active state and polarity bit.
  function automatic logic cs_level(input logic act, input logic pol);
    return ~(act ^ pol);
  endfunction

endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [WIDTH-1:0]           din,
  input  logic                       pop,
  output logic [WIDTH-1:0]           dout,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             do_push, do_pop;

  assign do_pop  = pop && (count != '0);
  assign do_push = push && (count != FULL_CNT);
  assign dout    = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wptr] <= din;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            cpol,
  input  logic            cpha,
  input  logic [15:0]     half,
  input  logic            can_start,
  input  logic [BITS-1:0] tx_byte,
  input  logic            miso,
  output logic            load,
  output logic            rx_push,
  output logic [BITS-1:0] rx_byte,
  output logic            sclk,
  output logic            mosi,
  output logic            busy
);
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);
  localparam logic [EW-1:0] LAST_LEAD = EW'(EDGES - 2);

  logic [15:0]     cnt;
  logic [EW-1:0]   edge_idx;
  logic            tog;
  logic [BITS-1:0] tx_sh;
  logic [BITS-2:0] rx_sh;
  logic            tick, sample_now, shift_now;

  assign tick       = busy && (cnt == 16'd0);
  assign sample_now = tick && (cpha ? edge_idx[0] : !edge_idx[0]);
  assign shift_now  = tick && (cpha ? (!edge_idx[0] && edge_idx != '0) : edge_idx[0]);
  assign load       = enable && !busy && can_start;
  assign rx_push    = sample_now && (edge_idx == (cpha ? LAST_EDGE : LAST_LEAD));
  assign rx_byte    = {rx_sh, miso};
  assign sclk       = cpol ^ tog;
  assign mosi       = tx_sh[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      edge_idx <= '0;
      tog      <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else if (!enable) begin
      busy     <= 1'b0;
      tog      <= 1'b0;
      edge_idx <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      cnt      <= half - 16'd1;
      edge_idx <= '0;
      tog      <= 1'b0;
      tx_sh    <= tx_byte;
    end else if (busy) begin
      if (tick) begin
        cnt      <= half - 16'd1;
        tog      <= ~tog;
        edge_idx <= edge_idx + 1'b1;
        if (sample_now) rx_sh <= {rx_sh[BITS-3:0], miso};
        if (shift_now)  tx_sh <= {tx_sh[BITS-2:0], 1'b0};
        if (edge_idx == LAST_EDGE) busy <= 1'b0;
      end else begin
        cnt <= cnt - 16'd1;
      end
    end
  end
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int NUM_CS     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [23:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_out,
  output logic              irq_done,
  output logic              irq_rx
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(FIFO_DEPTH);
  localparam logic [CW-1:0] NEED_CNT = CW'((FIFO_DEPTH * 3) / 4);

  ctrl_t       ctl;
  logic [15:0] div_q;
  logic [15:0] half;

  logic          wr_ctrl, wr_data, wr_div, rd_data;
  logic          tx_clr, rx_clr, tx_push, rx_pop;
  logic [7:0]    tx_head, rx_head, rx_byte;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          load, rx_push, busy;
  logic          xfer_on, cpol;
  logic [NUM_CS-1:0] cs_pol, cs_act;
  logic          done_flag, need_flag, rx_full;

  assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
  assign wr_data = reg_wr && (reg_addr == ADR_DATA);
  assign wr_div  = reg_wr && (reg_addr == ADR_DIV);
  assign rd_data = reg_rd && (reg_addr == ADR_DATA);

  assign tx_clr  = wr_ctrl && reg_wdata[CTL_FLUSH_TX];
  assign rx_clr  = wr_ctrl && reg_wdata[CTL_FLUSH_RX];
  assign tx_push = wr_data && xfer_on;
  assign rx_pop  = rd_data;

  assign xfer_on = ctl.xfer_on;
  assign cpol    = ctl.cpol;
  assign cs_pol  = ctl.cs_pol;
  assign half    = half_cycles(div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= '0;
      div_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctl.cs_sel  <= reg_wdata[CTL_SEL_LSB +: 2];
        ctl.cpha    <= reg_wdata[CTL_CPHA];
        ctl.cpol    <= reg_wdata[CTL_CPOL];
        ctl.xfer_on <= reg_wdata[CTL_XFER];
        ctl.ie_done <= reg_wdata[CTL_IE_DONE];
        ctl.ie_rx   <= reg_wdata[CTL_IE_RX];
        ctl.cs_pol  <= reg_wdata[CTL_POL_LSB +: 3];
      end
      if (wr_div) div_q <= reg_wdata;
    end
  end

  spi_sync_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(tx_push), .din(reg_wdata[7:0]),
    .pop(load), .dout(tx_head), .count(tx_cnt)
  );

  spi_sync_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_head), .count(rx_cnt)
  );

  spi_shift_engine #(.BITS(8)) u_engine (
    .clk(clk), .rst_n(rst_n), .enable(xfer_on),
    .cpol(ctl.cpol), .cpha(ctl.cpha), .half(half),
    .can_start((tx_cnt != '0) && (rx_cnt != FULL_CNT)),
    .tx_byte(tx_head), .miso(miso),
    .load(load), .rx_push(rx_push), .rx_byte(rx_byte),
    .sclk(sclk), .mosi(mosi), .busy(busy)
  );

  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs_act[i] = xfer_on && (ctl.cs_sel == 2'(i));
      assign cs_out[i] = cs_level(cs_act[i], cs_pol[i]);
    end
  endgenerate

  assign done_flag = xfer_on && (tx_cnt == '0) && !busy;
  assign need_flag = xfer_on && (rx_cnt >= NEED_CNT);
  assign rx_full   = (rx_cnt == FULL_CNT);
  assign irq_done  = done_flag && ctl.ie_done;
  assign irq_rx    = need_flag && ctl.ie_rx;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADR_CTRL: begin
        reg_rdata[CTL_SEL_LSB +: 2] = ctl.cs_sel;
        reg_rdata[CTL_CPHA]         = ctl.cpha;
        reg_rdata[CTL_CPOL]         = ctl.cpol;
        reg_rdata[CTL_XFER]         = ctl.xfer_on;
        reg_rdata[CTL_IE_DONE]      = ctl.ie_done;
        reg_rdata[CTL_IE_RX]        = ctl.ie_rx;
        reg_rdata[CTL_POL_LSB +: 3] = ctl.cs_pol;
        reg_rdata[ST_DONE]          = done_flag;
        reg_rdata[ST_RX_HAS]        = (rx_cnt != '0);
        reg_rdata[ST_TX_ROOM]       = (tx_cnt != FULL_CNT);
        reg_rdata[ST_RX_NEED]       = need_flag;
        reg_rdata[ST_RX_FULL]       = rx_full;
      end
      ADR_DATA: reg_rdata[7:0]  = (rx_cnt != '0) ? rx_head : 8'h00;
      ADR_DIV:  reg_rdata[15:0] = div_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_host_engine_chk.sv
module spi_host_engine_chk #(
  parameter int DEPTH = 16,
  parameter int NCS   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     xfer_on,
  input logic                     cpol,
  input logic                     busy,
  input logic                     sclk,
  input logic                     load,
  input logic                     rx_push,
  input logic                     tx_clr,
  input logic                     rx_clr,
  input logic [$clog2(DEPTH):0]   tx_cnt,
  input logic [$clog2(DEPTH):0]   rx_cnt,
  input logic [NCS-1:0]           cs_out,
  input logic [NCS-1:0]           cs_pol,
  input logic                     irq_done
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  AST_CS_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_on |-> (cs_out == ~cs_pol)); // R3

  AST_SCLK_REST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol)); // R5

  AST_NO_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (rx_cnt != FULL)); // R7

  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (xfer_on && rx_cnt != FULL && tx_cnt != '0)); // R7

  AST_TX_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> (tx_cnt == '0)); // R4

  AST_RX_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (rx_cnt == '0)); // R4

  AST_IRQ_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (xfer_on && tx_cnt == '0 && !busy)); // R8

  AST_BUSY_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_on) |=> !busy); // R3
endmodule

bind spi_host_engine spi_host_engine_chk #(.DEPTH(FIFO_DEPTH), .NCS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_on(xfer_on), .cpol(cpol), .busy(busy),
  .sclk(sclk), .load(load), .rx_push(rx_push), .tx_clr(tx_clr), .rx_clr(rx_clr),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .cs_out(cs_out), .cs_pol(cs_pol),
  .irq_done(irq_done)
);

// File: tb/spi_host_engine_bench.sv
module spi_host_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [23:0] reg_rdata;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic [2:0]  cs_out;
  logic        irq_done, irq_rx;

  int checks = 0, errors = 0;
  int cyc = 0;

  // shadow of what software wrote
  logic [1:0] sh_sel = 0;
  logic       sh_cpha = 0, sh_cpol = 0, sh_xfer = 0;
  logic [2:0] sh_pol = 0;
  int         exp_half = 32768;

  // serial monitor / slave state
  logic       prev_sclk = 1'b0;
  int         ecount = 0, bitidx = 0, last_edge = 0, last_iv = 0, nslave = 0;
  logic [7:0] cap = 0, sl_cur;
  logic [7:0] mosi_q[$], exp_rx[$], exp_tx[$];

  always #5 clk = ~clk;

  spi_host_engine u_spi_host_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_out(cs_out),
    .irq_done(irq_done), .irq_rx(irq_rx)
  );

  function automatic logic [7:0] slave_byte(int n);
    return 8'(n * 37 + 90);
  endfunction

  function automatic logic [15:0] ctlw(int sel, int cpha, int cpol, int flush,
                                       int xfer, int ied, int ier, int pol);
    return 16'(sel + cpha * 4 + cpol * 8 + flush * 16 + xfer * 128 +
               ied * 256 + ier * 512 + pol * 1024);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference model of the pins, compared every clock
  initial sl_cur = slave_byte(0);
  always @(negedge clk) begin
    logic [2:0] exp_cs;
    bit sampling;
    cyc++;
    if (rst_n) begin
      for (int i = 0; i < 3; i++)
        exp_cs[i] = (sh_xfer && sh_sel == 2'(i)) ? sh_pol[i] : !sh_pol[i];
      if (cs_out !== exp_cs) chk(0, "R2/R9 chip-select pins", 32'(cs_out), 32'(exp_cs));
      if (sclk !== prev_sclk && !(ecount == 0 && sclk == sh_cpol)) begin
        if (ecount > 0) begin
          last_iv = cyc - last_edge;
          chk(last_iv == exp_half, "R1 half period", last_iv, exp_half);
        end
        last_edge = cyc;
        ecount++;
        sampling = sh_cpha ? (sclk == sh_cpol) : (sclk != sh_cpol);
        if (sampling) begin
          cap = {cap[6:0], mosi};
          bitidx++;
          if (bitidx == 8) begin
            mosi_q.push_back(cap);
            exp_rx.push_back(sl_cur);
            nslave++;
            sl_cur = slave_byte(nslave);
            bitidx = 0;
          end
        end
        if (ecount == 16) ecount = 0;
      end
      miso <= sl_cur[7 - bitidx];
    end
    prev_sclk = sclk;
  end

  initial begin
    #1_900_000;
    chk(0, "watchdog", cyc, 190000);
    finish_run();
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    if (a == 2'd0) begin
      sh_sel = d[1:0]; sh_cpha = d[2]; sh_cpol = d[3]; sh_xfer = d[7]; sh_pol = d[12:10];
    end else if (a == 2'd2) begin
      int dd;
      dd = int'(d) - (int'(d) % 2);
      if (dd == 0) dd = 65536;
      exp_half = dd / 2;
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [23:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    wr(2'd1, {8'h00, b});
    exp_tx.push_back(b);
  endtask

  task automatic wait_done();
    logic [23:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd0, s);
      if (s[16]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_mode(input int cpha, input int cpol, input logic [15:0] dv,
                          input int n, input int seed);
    logic [23:0] s;
    wr(2'd2, dv);
    wr(2'd0, ctlw(1, cpha, cpol, 3, 1, 1, 0, 0));
    mosi_q.delete(); exp_rx.delete(); exp_tx.delete();
    for (int i = 0; i < n; i++) send(8'(seed + i * 53));
    wait_done();
    chk(sclk == 1'(cpol), "R5 sclk rest level", sclk, cpol);
    chk(mosi_q.size() == n, "R5 byte count", mosi_q.size(), n);
    for (int i = 0; i < n && i < mosi_q.size(); i++)
      chk(mosi_q[i] == exp_tx[i], "R5 MOSI byte MSB first", mosi_q[i], exp_tx[i]);
    for (int i = 0; i < n; i++) begin
      rd(2'd1, s);
      chk(s[7:0] == exp_rx[i], "R11 RX byte order", s[7:0], exp_rx[i]);
    end
    rd(2'd0, s);
    chk(s[16] == 1'b1 && s[17] == 1'b0, "R6 done after drain", s, 32'h10000);
    chk(irq_done == 1'b1, "R8 irq_done", irq_done, 1);
  endtask

  initial begin
    logic [23:0] s;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(2'd0, s);
    chk(s == 24'h040000, "R11 reset status", s, 24'h040000);
    rd(2'd2, s);
    chk(s == 24'h0, "R11 reset divider", s, 0);
    chk(cs_out == 3'b111, "R9 reset cs lines high", cs_out, 3'b111);
    chk(sclk == 1'b0 && irq_done == 1'b0 && irq_rx == 1'b0, "R8 reset idle", {sclk, irq_done, irq_rx}, 0);

    // data writes while inactive are discarded
    wr(2'd1, 16'h00AA);
    wr(2'd0, ctlw(0, 0, 0, 0, 1, 0, 0, 0));
    repeat (40) @(negedge clk);
    chk(mosi_q.size() == 0, "R10 write while inactive dropped", mosi_q.size(), 0);
    rd(2'd0, s);
    chk(s[16] == 1'b1, "R10 done with nothing queued", s[16], 1);

    // four modes, several dividers
    run_mode(0, 0, 16'd4, 3, 8'h3C);
    run_mode(1, 0, 16'd7, 2, 8'hA1);
    run_mode(0, 1, 16'd2, 4, 8'h5E);
    run_mode(1, 1, 16'd6, 2, 8'hF0);

    // done cleared by new data
    send(8'h81);
    rd(2'd0, s);
    chk(s[16] == 1'b0, "R6 done cleared by write", s[16], 0);
    wait_done();
    mosi_q.delete(); exp_rx.delete();

    // chip select codes and polarities
    for (int sel = 0; sel < 4; sel++) begin
      wr(2'd0, ctlw(sel, 0, 0, 0, 1, 0, 0, 5));
      repeat (2) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        logic e;
        e = (sel == i) ? ((5 >> i) & 1) : !((5 >> i) & 1);
        chk(cs_out[i] == e, "R2 select code", cs_out[i], e);
      end
    end
    wr(2'd0, ctlw(1, 0, 0, 0, 0, 1, 0, 6));
    repeat (2) @(negedge clk);
    chk(cs_out == 3'b001, "R3 all inactive when off", cs_out, 3'b001);
    rd(2'd0, s);
    chk(s[16] == 1'b0 && irq_done == 1'b0, "R3 done reads 0 when off", s[16], 0);

    // RX threshold, full stall, flush
    wr(2'd2, 16'd2);
    wr(2'd0, ctlw(0, 0, 0, 3, 1, 0, 1, 0));
    for (int i = 0; i < 11; i++) send(8'(i + 1));
    wait_done();
    rd(2'd0, s);
    chk(s[19] == 1'b0 && irq_rx == 1'b0, "R7 11 entries below threshold", {s[19], irq_rx}, 0);
    send(8'h0C);
    wait_done();
    rd(2'd0, s);
    chk(s[19] == 1'b1 && irq_rx == 1'b1, "R7/R8 12 entries need reading", {s[19], irq_rx}, 3);
    for (int i = 0; i < 4; i++) send(8'(i + 13));
    wait_done();
    rd(2'd0, s);
    chk(s[20] == 1'b1, "R7 rx full", s[20], 1);
    base = mosi_q.size();
    send(8'h71); send(8'h72);
    repeat (100) @(negedge clk);
    chk(mosi_q.size() == base, "R7 full stalls shifting", mosi_q.size(), base);
    rd(2'd0, s);
    chk(s[16] == 1'b0, "R6 not done while stalled", s[16], 0);
    rd(2'd1, s);
    chk(s[7:0] == exp_rx[0], "R11 head byte", s[7:0], exp_rx[0]);
    repeat (100) @(negedge clk);
    chk(mosi_q.size() == base + 1, "R7 one slot frees one byte", mosi_q.size(), base + 1);
    wr(2'd0, ctlw(0, 0, 0, 0, 0, 0, 1, 0));
    rd(2'd0, s);
    chk(s[19] == 1'b0 && irq_rx == 1'b0, "R3 need flag reads 0 when off", {s[19], irq_rx}, 0);
    wr(2'd0, ctlw(0, 0, 0, 3, 1, 0, 1, 0));
    rd(2'd0, s);
    chk(s[5:4] == 2'b00 && s[17] == 1'b0 && s[16] == 1'b1, "R4 flush with start", s, 24'h050080);
    repeat (100) @(negedge clk);
    chk(mosi_q.size() == base + 1, "R4 flushed byte never shifted", mosi_q.size(), base + 1);

    // zero divider means 65536, then abort mid-byte
    wr(2'd2, 16'd0);
    wr(2'd0, ctlw(2, 0, 0, 0, 1, 0, 0, 0));
    send(8'hC3);
    last_iv = 0;
    for (int i = 0; i < 120000 && last_iv == 0; i++) @(negedge clk);
    chk(last_iv == 32768, "R1 divider zero", last_iv, 32768);
    wr(2'd0, ctlw(2, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    #1;
    ecount = 0; bitidx = 0;
    base = mosi_q.size();
    repeat (40) @(negedge clk);
    chk(sclk == 1'b0 && cs_out == 3'b111, "R3 abort idles pins", {sclk, cs_out}, 4'b0111);
    chk(mosi_q.size() == base, "R3 aborted byte not completed", mosi_q.size(), base);

    finish_run();
  end
endmodule